// File: doc/BRIEF.md
# Effective Address Generator for 64-bit Instruction Mode

This block turns the decoded operand fields of a memory instruction into a linear address. A request carries an addressing form, the register values that take part, a scale code, a displacement and its width, the address of the following instruction, and a segment-base value. One cycle later the block presents the finished address together with a one-cycle valid pulse.

Three forms are supported. The first adds an optional base, an optional scaled index and a sign-extended displacement. The second adds a 32-bit displacement to the address of the next instruction. The third takes a complete 64-bit offset as the address. A narrow address-size flag limits the first two forms to 32-bit arithmetic, and the result is zero-extended. The base of a thread-local segment is added only after that narrowing, at full width. Every other segment is treated as having a base of zero.

Top module: `ea_gen64`

## Requirements
- R1: `disp_sz` picks the displacement width. 0 means no displacement, 1 means bits [7:0], 2 means bits [15:0] and 3 means bits [31:0] of `disp_val`. The chosen field is sign-extended to 64 bits before it is added.
- R2: `scale_code` values 0, 1, 2 and 3 multiply the index by 1, 2, 4 and 8.
- R3: Form code 1 (instruction-relative) gives `next_ip` plus `disp_val[31:0]` sign-extended. `base_val`, `index_val`, `disp_sz` and `scale_code` have no effect in this form.
- R4: With `narrow_addr` = 1, forms 0, 1 and 3 use only the low 32 bits of the base, index and `next_ip`. The sum keeps only its low 32 bits, and bits [63:32] become zero.
- R5: With `seg_fsgs` = 1, the full 64-bit `seg_base` is added after any narrowing, and the total wraps modulo 2^64.
- R6: With `seg_fsgs` = 0, `seg_base` has no effect on the address.
- R7: Form code 2 (absolute) uses `abs_off` unchanged as the effective address, whatever the value of `narrow_addr`.
- R8: `base_en` = 0 or `index_en` = 0 drops that term from the sum. Form code 3 behaves the same as form code 0 (base, index and displacement).
- R9: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` is high. `lin_addr` then holds the address for that request and keeps its value until the next request.
- R10: During reset, `out_valid` is 0 and `lin_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| form | input | 2 | 0/3 base-index, 1 instruction-relative, 2 absolute |
| base_en | input | 1 | Base register takes part |
| base_val | input | AW | Base register value |
| index_en | input | 1 | Index register takes part |
| index_val | input | AW | Index register value |
| scale_code | input | 2 | Index scale select |
| disp_val | input | 32 | Raw displacement |
| disp_sz | input | 2 | Displacement width select |
| next_ip | input | AW | Address of the next instruction |
| abs_off | input | AW | Full offset for the absolute form |
| narrow_addr | input | 1 | 32-bit address-size override |
| seg_fsgs | input | 1 | Segment with a nonzero base is selected |
| seg_base | input | AW | Segment base value |
| out_valid | output | 1 | Address valid, one cycle |
| lin_addr | output | AW | Linear address |

## Verification
The bench builds the block with its default widths: a 64-bit address and a 32-bit narrow size. At these widths the cases that matter can all be reached. A narrow sum can carry out of bit 31 and must be dropped. A negative displacement can wrap the narrow result to 0xFFFFFFFF. A segment base whose upper half is nonzero must survive after narrowing. A full-width sum can overflow bit 63. Register values are given junk upper halves, so any leak from those bits shows up in the result.

// File: rtl/ea_gen64.sv
module ea_gen64 #(
  parameter int AW = 64,
  parameter int NW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    form,
  input  logic          base_en,
  input  logic [AW-1:0] base_val,
  input  logic          index_en,
  input  logic [AW-1:0] index_val,
  input  logic [1:0]    scale_code,
  input  logic [31:0]   disp_val,
  input  logic [1:0]    disp_sz,
  input  logic [AW-1:0] next_ip,
  input  logic [AW-1:0] abs_off,
  input  logic          narrow_addr,
  input  logic          seg_fsgs,
  input  logic [AW-1:0] seg_base,
  output logic          out_valid,
  output logic [AW-1:0] lin_addr
);
  localparam logic [AW-1:0] LOW_MASK = {{(AW-NW){1'b0}}, {NW{1'b1}}};
  localparam logic [1:0] F_REL = 2'd1;
  localparam logic [1:0] F_ABS = 2'd2;

  logic [AW-1:0] disp_ext, disp32_ext, base_m, idx_m, ip_m, sum, trunc, ea;
  logic          cut;

  always_comb begin
    unique case (disp_sz)
      2'd0: disp_ext = '0;
      2'd1: disp_ext = {{(AW-8){disp_val[7]}}, disp_val[7:0]};
      2'd2: disp_ext = {{(AW-16){disp_val[15]}}, disp_val[15:0]};
      default: disp_ext = {{(AW-32){disp_val[31]}}, disp_val};
    endcase
  end

  assign disp32_ext = {{(AW-32){disp_val[31]}}, disp_val};
  assign cut    = narrow_addr && (form != F_ABS);
  assign base_m = (base_en ? base_val : '0) & (narrow_addr ? LOW_MASK : '1);
  assign idx_m  = ((index_en ? index_val : '0) & (narrow_addr ? LOW_MASK : '1)) << scale_code;
  assign ip_m   = next_ip & (narrow_addr ? LOW_MASK : '1);

  always_comb begin
    unique case (form)
      F_REL:   sum = ip_m + disp32_ext;
      F_ABS:   sum = abs_off;
      default: sum = base_m + idx_m + disp_ext;
    endcase
  end

  assign trunc = cut ? (sum & LOW_MASK) : sum;
  assign ea    = trunc + (seg_fsgs ? seg_base : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      lin_addr  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) lin_addr <= ea;
    end
  end

  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(lin_addr));
  assert_narrow_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && narrow_addr && !seg_fsgs && form != F_ABS) |=> (lin_addr[AW-1:NW] == '0));
  assert_abs_passthru_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && form == F_ABS && !seg_fsgs) |=> (lin_addr == $past(abs_off)));
endmodule

// File: tb/ea_gen64_tb_top.sv
module ea_gen64_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  form = '0;
  logic        base_en = 1'b0;
  logic [63:0] base_val = '0;
  logic        index_en = 1'b0;
  logic [63:0] index_val = '0;
  logic [1:0]  scale_code = '0;
  logic [31:0] disp_val = '0;
  logic [1:0]  disp_sz = '0;
  logic [63:0] next_ip = '0;
  logic [63:0] abs_off = '0;
  logic        narrow_addr = 1'b0;
  logic        seg_fsgs = 1'b0;
  logic [63:0] seg_base = '0;
  logic        out_valid;
  logic [63:0] lin_addr;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ea_gen64 dut_i (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .form(form),
    .base_en(base_en), .base_val(base_val), .index_en(index_en), .index_val(index_val),
    .scale_code(scale_code), .disp_val(disp_val), .disp_sz(disp_sz), .next_ip(next_ip),
    .abs_off(abs_off), .narrow_addr(narrow_addr), .seg_fsgs(seg_fsgs), .seg_base(seg_base),
    .out_valid(out_valid), .lin_addr(lin_addr));

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear();
    form = 2'd0; base_en = 0; base_val = '0; index_en = 0; index_val = '0;
    scale_code = 0; disp_val = '0; disp_sz = 0; next_ip = '0; abs_off = '0;
    narrow_addr = 0; seg_fsgs = 0; seg_base = '0;
  endtask

  task automatic issue(string req, logic [63:0] exp);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, {63'd0, out_valid}, 64'd1);
    check(req, lin_addr, exp);
    clear();
    @(negedge clk);
    check("R9 single-cycle valid", {63'd0, out_valid}, 64'd0);
    check("R9 hold", lin_addr, exp);
  endtask

  task automatic t_reset();
    check("R10 valid", {63'd0, out_valid}, 64'd0);
    check("R10 addr", lin_addr, 64'd0);
  endtask

  task automatic t_disp_scale();
    clear(); base_en = 1; base_val = 64'h1000; index_en = 1; index_val = 64'h10;
    scale_code = 2'd3; disp_sz = 2'd1; disp_val = 32'h1234_56F0;
    issue("R1 R2 disp8 x8", 64'h1070);
    base_en = 1; base_val = 64'h10_0000; disp_sz = 2'd2; disp_val = 32'hFFFF_8000;
    issue("R1 disp16 neg", 64'hF_8000);
    disp_sz = 2'd3; disp_val = 32'h8000_0000;
    issue("R1 disp32 neg", 64'hFFFF_FFFF_8000_0000);
    base_en = 1; base_val = 64'h100; disp_sz = 2'd0; disp_val = 32'hFFFF_FFFF;
    issue("R1 no disp", 64'h100);
    for (int s = 0; s < 4; s++) begin
      index_en = 1; index_val = 64'h3; scale_code = 2'(s);
      issue("R2 scale", 64'h3 << s);
    end
  endtask

  task automatic t_iprel();
    clear(); form = 2'd1; next_ip = 64'h0000_7FFF_0000_1000; disp_val = 32'hFFFF_FFF0;
    base_en = 1; base_val = 64'hAAAA; index_en = 1; index_val = 64'h5555;
    scale_code = 2'd2; disp_sz = 2'd1;
    issue("R3 ip-relative", 64'h0000_7FFF_0000_0FF0);
  endtask

  task automatic t_narrow();
    clear(); narrow_addr = 1; base_en = 1; base_val = 64'hDEAD_0000_FFFF_FFF0;
    index_en = 1; index_val = 64'hAAAA_0000_0000_0020;
    issue("R4 carry dropped", 64'h10);
    narrow_addr = 1; base_en = 1; base_val = 64'h1; disp_sz = 2'd1; disp_val = 32'hFE;
    issue("R4 wrap negative", 64'hFFFF_FFFF);
    narrow_addr = 1; form = 2'd1; next_ip = 64'h1234_0000_FFFF_FFFC; disp_val = 32'h8;
    issue("R4 ip-relative narrow", 64'h4);
  endtask

  task automatic t_seg();
    clear(); narrow_addr = 1; seg_fsgs = 1; seg_base = 64'hFFFF_FFFF_0000_0000;
    base_en = 1; base_val = 64'h0000_0001_FFFF_FFF0; index_en = 1; index_val = 64'h20;
    issue("R5 base after narrowing", 64'hFFFF_FFFF_0000_0010);
    seg_fsgs = 1; seg_base = 64'h8000_0000_0000_0000;
    base_en = 1; base_val = 64'h8000_0000_0000_0004;
    issue("R5 full-width wrap", 64'h4);
    seg_fsgs = 0; seg_base = 64'h7777_0000_0000_0000; base_en = 1; base_val = 64'h40;
    issue("R6 seg base ignored", 64'h40);
  endtask

  task automatic t_abs();
    clear(); form = 2'd2; narrow_addr = 1; abs_off = 64'h1234_5678_9ABC_DEF0;
    base_en = 1; base_val = 64'h99;
    issue("R7 absolute not narrowed", 64'h1234_5678_9ABC_DEF0);
    form = 2'd2; abs_off = 64'hFFFF_FFFF_FFFF_FFF8; seg_fsgs = 1; seg_base = 64'h10;
    issue("R7 R5 absolute plus seg", 64'h8);
  endtask

  task automatic t_omit();
    clear(); form = 2'd3; base_en = 0; base_val = 64'h5A5A; index_en = 1;
    index_val = 64'h4; scale_code = 2'd1; disp_sz = 2'd1; disp_val = 32'h1;
    issue("R8 base omitted form3", 64'h9);
    form = 2'd0; base_en = 1; base_val = 64'h100; index_en = 0; index_val = 64'hFFFF;
    issue("R8 index omitted", 64'h100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_disp_scale();
    t_iprel();
    t_narrow();
    t_seg();
    t_abs();
    t_omit();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R9 watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule